// File: doc/BRIEF.md
# Three-Wire Serial Memory Erase Slave

This block models the slave end of a three-wire serial memory that accepts chip select, a serial clock and a data input, and answers on a data output that is driven only when the host checks status. Commands arrive one bit per rising serial-clock edge, most significant bit first. Two of them erase memory: one sets a single word to all ones, the other sets the whole array to all ones. Two more commands open and close a write-protect gate that every erase must pass.

An erase does not start when its last bit is clocked in. It starts when chip select falls after that bit. From then on it runs by itself, counting system clocks, and needs no serial clock. While it runs, the host can lower chip select for at least a minimum time and raise it again. The output then reads 0 while the erase is in progress and 1 once it has finished. All serial inputs are brought into the system clock domain through two-flop synchronisers. A combinational observation port shows any word of the array to the surrounding model.

Top module: `mw_erase_slave`

## Requirements
- R1: The single-word erase frame is a 1 start bit, opcode `11`, then 7 address bits MSB first. After it completes, the addressed word reads 16'hFFFF on `peek_data`, and its neighbouring words keep their values.
- R2: The erase-all frame is a 1 start bit, opcode `00`, address bits [6:5] = `10` with bits [4:0] ignored. After it completes, all 128 words read 16'hFFFF.
- R3: An erase starts on the chip-select falling edge that follows a complete frame. Zeros clocked before the start bit are ignored.
- R4: An erase completes TWC system clocks after it starts, with no serial-clock activity. Status reads busy before that point and ready after it.
- R5: When chip select is raised after an erase has started, following at least TCSL system clocks low, `dout_oe` is 1 and `dout` is 0 while the erase runs.
- R6: In that status window, `dout` is 1 once the erase has finished.
- R7: `dout_oe` is 0 after reset, while a frame is being shifted in (a start bit closes an open window), and when chip select was low for fewer than TCSL clocks.
- R8: Erases take effect only after the enable frame (opcode `00`, address [6:5] = `11`). They are blocked after the disable frame (opcode `00`, address [6:5] = `00`). The block resets to disabled.
- R9: Any frame clocked in while an erase is running is ignored.
- R10: Reset loads word i with 16'hA5C3 XOR {i,i}, where i is zero-extended to 8 bits. Opcodes `01` and `10` start nothing and change no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial command input |
| dout | output | 1 | Status output value |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| peek_addr | input | 7 | Observation port word address |
| peek_data | output | 16 | Contents of the word at `peek_addr` |

## Verification
The hardest case to reach is a full frame that arrives while an erase is still running. The host has to open a status window, shift a second complete erase frame and drop chip select again, all inside the TWC window. The bench keeps its serial-clock phases short enough for this. It then checks that no status window reopens and that the second word keeps its reset value. A second hard case is the status window that changes from busy to ready while chip select is held high. The bench samples that window well before and well after TWC, with the serial clock idle between the two samples.

// File: rtl/mw_erase_slave.sv
module mw_erase_slave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int TWC = 200,
  parameter int TCSL = 25,
  parameter logic [DATA_W-1:0] SEED = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sclk,
  input  logic              di,
  output logic              dout,
  output logic              dout_oe,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int FRAME = ADDR_W + 2;
  localparam int CW = $clog2(FRAME + 1);
  localparam int TW = $clog2(TWC + 1);
  localparam int LW = $clog2(TCSL + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_DONE} st_t;

  logic [2:0] cs_p, ck_p;
  logic [1:0] di_p;
  logic cs_s, di_s, cs_fall, cs_rise, ck_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= '0;
      ck_p <= '0;
      di_p <= '0;
    end else begin
      cs_p <= {cs_p[1:0], cs};
      ck_p <= {ck_p[1:0], sclk};
      di_p <= {di_p[0], di};
    end

  assign cs_s    = cs_p[1];
  assign di_s    = di_p[1];
  assign cs_fall = cs_p[2] & ~cs_p[1];
  assign cs_rise = ~cs_p[2] & cs_p[1];
  assign ck_rise = ~ck_p[2] & ck_p[1];

  st_t st;
  logic [CW-1:0] bcnt;
  logic [FRAME-2:0] sr;
  logic [FRAME-1:0] word;
  logic frame_end, start_bit;

  assign word      = {sr, di_s};
  assign frame_end = cs_s & ck_rise & (st == S_SHIFT) & (bcnt == CW'(FRAME - 1));
  assign start_bit = cs_s & ck_rise & (st == S_IDLE) & di_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      bcnt <= '0;
      sr   <= '0;
    end else if (!cs_s) begin
      st   <= S_IDLE;
      bcnt <= '0;
    end else if (ck_rise) begin
      case (st)
        S_IDLE: if (di_s) begin
          st   <= S_SHIFT;
          bcnt <= '0;
        end
        S_SHIFT: begin
          sr   <= word[FRAME-2:0];
          bcnt <= bcnt + 1'b1;
          if (bcnt == CW'(FRAME - 1)) st <= S_DONE;
        end
        default: st <= S_DONE;
      endcase
    end

  logic wen, pend, all_q, busy, armed, stat_en, fin;
  logic [ADDR_W-1:0] cmd_addr;
  logic [TW-1:0] tcnt;
  logic [LW-1:0] lowcnt;
  logic [1:0] op, pre;
  logic [DATA_W-1:0] mem [DEPTH];

  assign op  = word[FRAME-1:FRAME-2];
  assign pre = word[ADDR_W-1:ADDR_W-2];
  assign fin = busy && (tcnt == TW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wen      <= 1'b0;
      pend     <= 1'b0;
      all_q    <= 1'b0;
      cmd_addr <= '0;
    end else if (cs_fall) begin
      pend <= 1'b0;
    end else if (frame_end && !busy) begin
      if (op == 2'b11) begin
        pend     <= 1'b1;
        all_q    <= 1'b0;
        cmd_addr <= word[ADDR_W-1:0];
      end else if (op == 2'b00) begin
        case (pre)
          2'b11: wen <= 1'b1;
          2'b00: wen <= 1'b0;
          2'b10: begin
            pend  <= 1'b1;
            all_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (cs_fall && pend && wen && !busy) begin
      busy <= 1'b1;
      tcnt <= TW'(TWC);
    end else if (busy) begin
      tcnt <= tcnt - 1'b1;
      if (tcnt == TW'(1)) busy <= 1'b0;
    end

  function automatic logic [DATA_W-1:0] init_word(input int i);
    logic [DATA_W-1:0] v;
    v = DATA_W'(i) | (DATA_W'(i) << (DATA_W / 2));
    return SEED ^ v;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i);
    end else if (fin) begin
      if (all_q) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
        mem[cmd_addr] <= '1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lowcnt <= '0;
    else if (cs_s) lowcnt <= '0;
    else if (lowcnt != LW'(TCSL)) lowcnt <= lowcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_en <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (stat_en && (cs_fall || start_bit)) begin
        stat_en <= 1'b0;
        armed   <= 1'b0;
      end else if (cs_rise && armed && lowcnt >= LW'(TCSL)) begin
        stat_en <= 1'b1;
      end
      if (cs_fall && pend && wen && !busy) armed <= 1'b1;
    end

  assign dout_oe   = stat_en & cs_s;
  assign dout      = stat_en & cs_s & ~busy;
  assign peek_data = mem[peek_addr];
endmodule

// File: rtl/mw_erase_slave_chk.sv
module mw_erase_slave_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              fin,
  input logic              cs_fall,
  input logic              wen,
  input logic              all_q,
  input logic              dout,
  input logic              dout_oe,
  input logic [DATA_W-1:0] mem_tgt
);
  p_start_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall));
  p_start_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));
  p_selftimed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fin |=> busy);
  p_busy_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe && busy |-> !dout);
  p_ready_reads_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe && !busy |-> dout);
  p_quiet_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !dout_oe);
  p_word_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !all_q |-> mem_tgt == '1);
  p_array_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && all_q |-> mem_tgt == '1);
endmodule

bind mw_erase_slave mw_erase_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .fin(fin), .cs_fall(cs_fall),
  .wen(wen), .all_q(all_q), .dout(dout), .dout_oe(dout_oe),
  .mem_tgt(mem[cmd_addr])
);

// File: tb/mw_erase_slave_tb.sv
module mw_erase_slave_tb;
  localparam int TWC = 200;
  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, di = 0;
  logic dout, dout_oe;
  logic [6:0] peek_addr = '0;
  logic [15:0] peek_data;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mw_erase_slave #(.TWC(TWC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
    .dout(dout), .dout_oe(dout_oe), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  // lead zeros in [8:7], address in [6:0]
  localparam logic [8:0] VEC [6] = '{9'h005, 9'h0FF, 9'h100, 9'h1C0, 9'h02A, 9'h093};

  function automatic logic [15:0] init_val(input int i);
    return 16'hA5C3 ^ {i[7:0], i[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bitc(input logic b);
    di = b;
    repeat (4) @(posedge clk);
    sclk = 1;
    repeat (4) @(posedge clk);
    sclk = 0;
  endtask

  task automatic frame(input int lead, input logic [1:0] op, input logic [6:0] a);
    cs = 1;
    repeat (4) @(posedge clk);
    for (int i = 0; i < lead; i++) bitc(1'b0);
    bitc(1'b1);
    bitc(op[1]);
    bitc(op[0]);
    for (int i = 6; i >= 0; i--) bitc(a[i]);
    repeat (4) @(posedge clk);
  endtask

  task automatic drop(input int n);
    cs = 0;
    repeat (n) @(posedge clk);
  endtask

  task automatic raise;
    cs = 1;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input string req, input logic [6:0] a, input logic [15:0] exp);
    peek_addr = a;
    @(negedge clk);
    check(req, peek_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R7 reset oe", dout_oe, 0);
    rst_n = 1;
    peek("R10 reset word 05", 7'h05, init_val(5));
    peek("R10 reset word 7F", 7'h7F, init_val(127));

    // disabled after reset
    frame(0, 2'b11, 7'h05);
    drop(40);
    raise;
    check("R8 no window while disabled", dout_oe, 0);
    repeat (TWC + 20) @(posedge clk);
    drop(4);
    peek("R8 blocked erase", 7'h05, init_val(5));

    frame(0, 2'b00, 7'b1100000);
    drop(10);

    foreach (VEC[k]) begin
      logic [6:0] a;
      a = VEC[k][6:0];
      frame(int'(VEC[k][8:7]), 2'b11, a);
      drop(40);
      raise;
      check("R5 oe busy", dout_oe, 1);
      check("R5 busy value", dout, 0);
      repeat (100) @(posedge clk);
      @(negedge clk);
      check("R4 still busy before TWC", dout, 0);
      repeat (120) @(posedge clk);
      @(negedge clk);
      check("R6 ready value", dout, 1);
      check("R4 done without clk", dout_oe, 1);
      bitc(1'b1);
      @(negedge clk);
      check("R7 start bit closes window", dout_oe, 0);
      drop(4);
      peek("R1 word erased", a, 16'hFFFF);
      peek("R1 neighbour kept", a ^ 7'h01, init_val(int'(a ^ 7'h01)));
      peek("R3 lead zeros ignored", a, 16'hFFFF);
    end

    // mid-frame status is off
    cs = 1;
    repeat (4) @(posedge clk);
    bitc(1'b1);
    bitc(1'b1);
    @(negedge clk);
    check("R7 oe during shift", dout_oe, 0);
    drop(4);

    // short CS low
    frame(0, 2'b11, 7'h33);
    drop(8);
    raise;
    check("R7 short low no window", dout_oe, 0);
    repeat (TWC + 20) @(posedge clk);
    drop(4);
    peek("R3 launch on fall", 7'h33, 16'hFFFF);

    // command while busy
    frame(0, 2'b11, 7'h50);
    drop(40);
    raise;
    check("R5 busy window", dout, 0);
    frame(0, 2'b11, 7'h51);
    drop(40);
    raise;
    check("R9 no relaunch window", dout_oe, 0);
    repeat (TWC + 50) @(posedge clk);
    drop(4);
    peek("R9 first done", 7'h50, 16'hFFFF);
    peek("R9 second ignored", 7'h51, init_val(8'h51));

    // other opcodes
    frame(0, 2'b01, 7'h60);
    drop(40);
    raise;
    check("R10 op01 no window", dout_oe, 0);
    frame(0, 2'b10, 7'h61);
    drop(40);
    raise;
    check("R10 op10 no window", dout_oe, 0);
    repeat (TWC + 20) @(posedge clk);
    drop(4);
    peek("R10 op01 word kept", 7'h60, init_val(8'h60));
    peek("R10 op10 word kept", 7'h61, init_val(8'h61));

    // disable
    frame(0, 2'b00, 7'b0010101);
    drop(10);
    frame(0, 2'b11, 7'h70);
    drop(40);
    raise;
    check("R8 disabled no window", dout_oe, 0);
    repeat (TWC + 20) @(posedge clk);
    drop(4);
    peek("R8 disabled word kept", 7'h70, init_val(8'h70));

    // erase all
    frame(0, 2'b00, 7'b1101010);
    drop(10);
    frame(2, 2'b00, 7'b1010111);
    drop(40);
    raise;
    check("R2 busy", dout, 0);
    repeat (TWC + 20) @(posedge clk);
    @(negedge clk);
    check("R2 ready", dout, 1);
    drop(4);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      peek_addr = 7'(i);
      @(negedge clk);
      if (peek_data !== 16'hFFFF) bad++;
    end
    check("R2 words not ones", bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule